// File: doc/BRIEF.md
# Byte Transfer Sequencer with One-Shot Strong Pull-Up

This block sits between a byte-level command source and a single-wire bit slot engine. It takes one byte command at a time and breaks it into eight bit slots, least-significant bit first. For each slot it hands the slot engine one bit to drive. It then waits for the engine to finish the slot and report the level it sampled. There are three operations. A write sends the data bits. A read releases the line in every slot and assembles the sampled levels. A touch sends the data bits and returns what came back on each released slot.

A separate request register holds a strong pull-up duration in milliseconds, and a non-zero value arms a pull-up for the next write or touch only. When that request is pending, the strong pull-up enable rises together with the slot request for the last bit. After the last slot completes, the enable stays high for the programmed number of milliseconds. The millisecond count is derived from a microsecond tick input through an internal prescaler. The enable then drops, the request is cleared and the byte completes. The block stays busy for the whole hold and accepts no new command during it.

Top module: `byte_xfer`

## Requirements
- R1: Slot i of a byte (i = 0 first, up to 7) carries data bit i on `slotBit` for write and touch commands, so bits go out least-significant first.
- R2: A read command (`cmdOp` = 2'b01) issues eight slots with `slotBit` = 1, and the sampled level of slot i lands in bit i of `rspData`.
- R3: A touch command (`cmdOp` = 2'b10) returns, in bit i of `rspData`, the sampled level of slot i when data bit i is 1 and 0 when data bit i is 0.
- R4: A write command (`cmdOp` = 2'b00, and the unused code 2'b11, which behaves the same) returns `rspData` = 0.
- R5: With a non-zero pull-up request pending, a write or touch raises `pullupEn` in the same cycle that the slot request for bit 7 appears. `pullupEn` stays low during slots 0 to 6.
- R6: After the bit-7 slot completes, `pullupEn` stays high for exactly duration × US_PER_MS `usTick` pulses. `rspValid` is asserted in the first cycle in which `pullupEn` is low again.
- R7: A serviced pull-up request is cleared, so the next write without a new request shows no strong pull-up.
- R8: Writing a duration of 0 to the request register cancels a request that is still pending.
- R9: A read never raises `pullupEn` and leaves a pending request in place for the next write or touch.
- R10: `cmdReady` is high only while idle. It is low from acceptance through the response cycle, including every cycle of a pull-up hold.
- R11: After reset, `cmdReady` is 1 and `slotReq`, `pullupEn` and `rspValid` are 0.
- R12: `slotReq` with its `slotBit` is held stable until `slotDone` arrives. Each `slotDone` pulse completes exactly one slot.
- R13: Each command produces exactly one single-cycle `rspValid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Byte command offered |
| cmdReady | output | 1 | Block idle, command taken when valid |
| cmdOp | input | 2 | 00 write, 01 read, 10 touch, 11 write |
| cmdData | input | BITS | Byte to send |
| rspValid | output | 1 | Byte finished, one-cycle pulse |
| rspData | output | BITS | Assembled result |
| puWrite | input | 1 | Load the pull-up request register |
| puDuration | input | DUR_W | Pull-up hold in milliseconds, 0 cancels |
| usTick | input | 1 | One-microsecond tick |
| pullupEn | output | 1 | Strong pull-up enable |
| slotReq | output | 1 | Slot requested from the slot engine |
| slotBit | output | 1 | Bit for the slot, 1 also means release and sample |
| slotDone | input | 1 | Slot engine finished the current slot |
| slotSample | input | 1 | Level sampled in that slot, valid with slotDone |

## Verification
The bench builds the block with BITS = 8, US_PER_MS = 3 and DUR_W = 3. With these values every possible request duration, 0 through 7, needs at most 21 hold cycles. That makes it cheap to sweep all of them against every operation code, several data and sample patterns, and varying slot-engine latency. The short hold also lets the bench count every cycle of each hold exactly. The same sweep reaches the one-shot clearing, the pending-through-read case and cancellation by a zero write.

// File: rtl/byte_xfer_pkg.sv
package byte_xfer_pkg;
  localparam logic [1:0] OP_WRITE = 2'b00;
  localparam logic [1:0] OP_READ  = 2'b01;
  localparam logic [1:0] OP_TOUCH = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SLOT = 2'd1,
    ST_HOLD = 2'd2,
    ST_DONE = 2'd3
  } xferState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic load;     // take a new command
    logic capture;  // a slot finished: store sample, advance bit index
    logic arm;      // raise strong pull-up before the last slot
    logic holdRun;  // pull-up hold in progress, count time
    logic finish;   // hold over: drop pull-up, clear request
  } xferStrobe_t;
endpackage

// File: rtl/byte_xfer_ctrl.sv
module byte_xfer_ctrl
  import byte_xfer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic        slotDone,
  input  logic        isLastBit,
  input  logic        isPreLastBit,
  input  logic        armOk,
  input  logic        pullupOn,
  input  logic        holdDone,
  output logic        cmdReady,
  output logic        slotReq,
  output logic        rspValid,
  output xferStrobe_t strobe
);
  xferState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: if (cmdValid) begin
        strobe.load = 1'b1;
        nextState   = ST_SLOT;
      end
      ST_SLOT: if (slotDone) begin
        strobe.capture = 1'b1;
        strobe.arm     = isPreLastBit & armOk;
        if (isLastBit) nextState = pullupOn ? ST_HOLD : ST_DONE;
      end
      ST_HOLD: begin
        strobe.holdRun = 1'b1;
        if (holdDone) begin
          strobe.finish = 1'b1;
          nextState     = ST_DONE;
        end
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign cmdReady = (state == ST_IDLE);
  assign slotReq  = (state == ST_SLOT);
  assign rspValid = (state == ST_DONE);
endmodule

// File: rtl/byte_xfer_dp.sv
module byte_xfer_dp
  import byte_xfer_pkg::*;
#(
  parameter int BITS      = 8,
  parameter int US_PER_MS = 1000,
  parameter int DUR_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  xferStrobe_t      strobe,
  input  logic [1:0]       cmdOp,
  input  logic [BITS-1:0]  cmdData,
  input  logic             slotSample,
  input  logic             puWrite,
  input  logic [DUR_W-1:0] puDuration,
  input  logic             usTick,
  output logic             slotBit,
  output logic [BITS-1:0]  rspData,
  output logic             isLastBit,
  output logic             isPreLastBit,
  output logic             armOk,
  output logic             pullupEn,
  output logic             holdDone
);
  localparam int IDX_W = (BITS > 1) ? $clog2(BITS) : 1;
  localparam int US_W  = $clog2(US_PER_MS + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BITS - 1);
  localparam logic [IDX_W-1:0] PRE_IDX  = IDX_W'(BITS - 2);
  localparam logic [US_W-1:0]  US_LAST  = US_W'(US_PER_MS - 1);

  logic [1:0]       opReg;
  logic [BITS-1:0]  dataReg;
  logic [BITS-1:0]  resultReg;
  logic [IDX_W-1:0] bitIdx;
  logic [DUR_W-1:0] reqDur, holdDur, msCnt;
  logic [US_W-1:0]  usCnt;
  logic             returnsSample;

  assign returnsSample = (opReg == OP_READ) || (opReg == OP_TOUCH);
  assign slotBit       = (opReg == OP_READ) ? 1'b1 : dataReg[bitIdx];
  assign isLastBit     = (bitIdx == LAST_IDX);
  assign isPreLastBit  = (bitIdx == PRE_IDX);
  assign armOk         = (opReg != OP_READ) && (reqDur != '0);
  assign holdDone      = strobe.holdRun && usTick && (usCnt == US_LAST)
                         && (msCnt == holdDur - DUR_W'(1));
  assign rspData       = resultReg;

  // byte sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg     <= OP_WRITE;
      dataReg   <= '0;
      resultReg <= '0;
      bitIdx    <= '0;
    end else if (strobe.load) begin
      opReg     <= cmdOp;
      dataReg   <= cmdData;
      resultReg <= '0;
      bitIdx    <= '0;
    end else if (strobe.capture) begin
      resultReg[bitIdx] <= returnsSample & slotBit & slotSample;
      bitIdx            <= bitIdx + IDX_W'(1);
    end
  end

  // one-shot request register; a new write wins over the clear
  always_ff @(posedge clk) begin
    if (!rstN)              reqDur <= '0;
    else if (puWrite)       reqDur <= puDuration;
    else if (strobe.finish) reqDur <= '0;
  end

  // strong pull-up enable and hold timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pullupEn <= 1'b0;
      holdDur  <= '0;
      usCnt    <= '0;
      msCnt    <= '0;
    end else if (strobe.arm) begin
      pullupEn <= 1'b1;
      holdDur  <= reqDur;
      usCnt    <= '0;
      msCnt    <= '0;
    end else if (strobe.finish) begin
      pullupEn <= 1'b0;
    end else if (strobe.holdRun && usTick) begin
      if (usCnt == US_LAST) begin
        usCnt <= '0;
        msCnt <= msCnt + DUR_W'(1);
      end else begin
        usCnt <= usCnt + US_W'(1);
      end
    end
  end
endmodule

// File: rtl/byte_xfer.sv
module byte_xfer
  import byte_xfer_pkg::*;
#(
  parameter int BITS      = 8,
  parameter int US_PER_MS = 1000,
  parameter int DUR_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  output logic             cmdReady,
  input  logic [1:0]       cmdOp,
  input  logic [BITS-1:0]  cmdData,
  output logic             rspValid,
  output logic [BITS-1:0]  rspData,
  input  logic             puWrite,
  input  logic [DUR_W-1:0] puDuration,
  input  logic             usTick,
  output logic             pullupEn,
  output logic             slotReq,
  output logic             slotBit,
  input  logic             slotDone,
  input  logic             slotSample
);
  xferStrobe_t strobe;
  logic isLastBit, isPreLastBit, armOk, holdDone;

  byte_xfer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .slotDone(slotDone),
    .isLastBit(isLastBit), .isPreLastBit(isPreLastBit), .armOk(armOk),
    .pullupOn(pullupEn), .holdDone(holdDone), .cmdReady(cmdReady),
    .slotReq(slotReq), .rspValid(rspValid), .strobe(strobe)
  );

  byte_xfer_dp #(.BITS(BITS), .US_PER_MS(US_PER_MS), .DUR_W(DUR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdOp(cmdOp), .cmdData(cmdData),
    .slotSample(slotSample), .puWrite(puWrite), .puDuration(puDuration),
    .usTick(usTick), .slotBit(slotBit), .rspData(rspData),
    .isLastBit(isLastBit), .isPreLastBit(isPreLastBit), .armOk(armOk),
    .pullupEn(pullupEn), .holdDone(holdDone)
  );
endmodule

// File: rtl/byte_xfer_chk.sv
module byte_xfer_chk (
  input logic clk,
  input logic rstN,
  input logic cmdReady,
  input logic slotReq,
  input logic slotBit,
  input logic slotDone,
  input logic pullupEn,
  input logic rspValid
);
  // R10: never idle while a slot is outstanding
  p_ready_not_in_slot_r10: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> !slotReq);

  // R10: no command taken while the pull-up is held
  p_busy_in_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pullupEn && !slotReq) |-> !cmdReady);

  // R12: request and bit held until the slot engine finishes
  p_slot_stable_r12: assert property (@(posedge clk) disable iff (!rstN)
    (slotReq && !slotDone) |=> (slotReq && $stable(slotBit)));

  // R13: response is a single-cycle pulse
  p_rsp_pulse_r13: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R6: the pull-up ends exactly when the byte completes
  p_pullup_end_rsp_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pullupEn) |-> rspValid);

  // R5: the pull-up only starts alongside a slot request
  p_pullup_start_slot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pullupEn) |-> slotReq);
endmodule

bind byte_xfer byte_xfer_chk u_chk (
  .clk(clk), .rstN(rstN), .cmdReady(cmdReady), .slotReq(slotReq),
  .slotBit(slotBit), .slotDone(slotDone), .pullupEn(pullupEn),
  .rspValid(rspValid)
);

// File: tb/byte_xfer_tb.sv
module byte_xfer_tb;
  localparam int BITS = 8;
  localparam int USMS = 3;
  localparam int DW   = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'b00;
  logic [BITS-1:0] cmdData = '0;
  logic puWrite = 1'b0;
  logic [DW-1:0] puDuration = '0;
  logic usTick = 1'b1;
  logic slotDone = 1'b0;
  logic slotSample = 1'b0;
  logic cmdReady, rspValid, pullupEn, slotReq, slotBit;
  logic [BITS-1:0] rspData;

  int checks = 0;
  int fails  = 0;
  int reqModel = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  byte_xfer #(.BITS(BITS), .US_PER_MS(USMS), .DUR_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdData(cmdData), .rspValid(rspValid), .rspData(rspData),
    .puWrite(puWrite), .puDuration(puDuration), .usTick(usTick),
    .pullupEn(pullupEn), .slotReq(slotReq), .slotBit(slotBit),
    .slotDone(slotDone), .slotSample(slotSample)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic setReq(input int d);
    @(negedge clk);
    puWrite = 1'b1; puDuration = DW'(d);
    @(negedge clk);
    puWrite = 1'b0;
    reqModel = d;
  endtask

  task automatic runByte(input logic [1:0] op, input logic [BITS-1:0] data,
                         input logic [BITS-1:0] samp, input int lat);
    bit armed;
    bit busyErr;
    bit slotErr;
    int hold;
    int expRsp;
    armed = (op != 2'b01) && (reqModel != 0);
    @(negedge clk);
    check("R10 ready when idle", cmdReady, 1);
    cmdValid = 1'b1; cmdOp = op; cmdData = data;
    @(negedge clk);
    cmdValid = 1'b0;
    slotErr = 1'b0;
    for (int i = 0; i < BITS; i++) begin
      check("R12 slot requested", slotReq, 1);
      check((op == 2'b01) ? "R2 read slot bit" : "R1 lsb-first bit",
            slotBit, (op == 2'b01) ? 1 : int'(data[i]));
      check((op == 2'b01) ? "R9 read no pullup" : "R5 pullup at last bit",
            pullupEn, (i == BITS-1 && armed) ? 1 : 0);
      check("R10 busy in slot", cmdReady, 0);
      for (int k = 0; k < lat; k++) begin
        @(negedge clk);
        if (!slotReq || slotBit !== ((op == 2'b01) ? 1'b1 : data[i])) slotErr = 1'b1;
      end
      slotDone = 1'b1; slotSample = samp[i];
      @(negedge clk);
      slotDone = 1'b0;
    end
    check("R12 slot held until done", slotErr, 0);
    hold = 0; busyErr = 1'b0;
    while (pullupEn === 1'b1 && hold < 1000) begin
      if (cmdReady || slotReq || rspValid) busyErr = 1'b1;
      hold++;
      @(negedge clk);
    end
    check(armed ? "R6 hold length" : "R7 R8 no pullup", hold, armed ? reqModel*USMS : 0);
    check("R10 busy during hold", busyErr, 0);
    if (armed) reqModel = 0;
    check("R13 response pulse", rspValid, 1);
    if (op == 2'b01)      expRsp = int'(samp);
    else if (op == 2'b10) expRsp = int'(data & samp);
    else                  expRsp = 0;
    check((op == 2'b01) ? "R2 read data" : (op == 2'b10) ? "R3 touch data" : "R4 write data",
          int'(rspData), expRsp);
    @(negedge clk);
    check("R13 single pulse", rspValid, 0);
    check("R10 idle again", cmdReady, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 ready", cmdReady, 1);
    check("R11 slotReq", slotReq, 0);
    check("R11 pullup", pullupEn, 0);
    check("R11 rspValid", rspValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 ready after release", cmdReady, 1);

    // sweep: every duration, every op code, request re-armed only for p == 0
    for (int d = 0; d < (1 << DW); d++) begin
      for (int op = 0; op < 4; op++) begin
        for (int p = 0; p < 3; p++) begin
          logic [BITS-1:0] dat, smp;
          dat = BITS'(8'hA5 ^ (d*37 + op*11 + p*90));
          smp = BITS'(~dat ^ (8'h3C + d*5 + p));
          if (p == 0) setReq(d);
          runByte(2'(op), dat, smp, (d + op + p) % 3);
        end
      end
    end

    // R8: zero cancels a pending request
    setReq(5);
    setReq(0);
    runByte(2'b00, 8'hFF, 8'h00, 1);

    // R9: request survives a read and serves the following touch
    setReq(2);
    runByte(2'b01, 8'h00, 8'h96, 0);
    check("R9 pending after read", reqModel, 2);
    runByte(2'b10, 8'h81, 8'hFF, 2);
    // R7: cleared after service
    runByte(2'b00, 8'h7E, 8'h00, 0);

    // corner patterns with max duration
    setReq((1 << DW) - 1);
    runByte(2'b10, 8'hFF, 8'hFF, 0);
    runByte(2'b01, 8'h00, 8'h00, 1);
    runByte(2'b00, 8'h00, 8'hFF, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule